// File: doc/BRIEF.md
# Four-Operand Leading Zero Anticipator

This block estimates the normalization shift for the sum of four aligned, unsigned operand vectors before any adder has produced that sum. Each bit column is reduced to a count of ones (0 to 4). The count becomes three small symbols. Symbols from the column itself and its two lower neighbours drive one bit of an indicator vector that is two bits wider than an operand. A tree of 2-bit detect-and-merge cells then turns the highest set indicator bit into a binary shift count.

The estimate lands on the true leading one or one position below it. A downstream normalizer shifts by the reported amount and then applies at most a one-bit correction. When every operand is zero the block raises a flag and reports the full result width as the shift. A result is registered once per valid input cycle, so a new operand set can enter on every clock.

Top module: `lza4`

## Requirements
- R1: While reset is held and until the first valid input, `outValid`, `allZero` and `shiftAmt` are all 0.
- R2: An operand set presented with `inValid` high produces its result with `outValid` high on the following cycle. `outValid` is low in any cycle that does not follow a valid input.
- R3: For each column i (0 to WIDTH-1), let n be the number of ones among the four operand bits. The block forms three symbols: nonZero (n >= 1), pairUp (n >= 2) and allFour (n == 4).
- R4: The indicator has WIDTH+2 bits. Bit m is nonZero[m] OR pairUp[m-1] OR (nonZero[m-1] AND pairUp[m-2]) OR allFour[m-2]. A column index outside 0..WIDTH-1 contributes 0.
- R5: When the indicator is not all zero, `shiftAmt` equals WIDTH+1 minus the index of its highest set bit, and `allZero` is 0.
- R6: For any nonzero operand set, the leading one of the exact (WIDTH+2)-bit sum sits at bit WIDTH+1-`shiftAmt` or exactly one position higher.
- R7: When all four operands are zero, `allZero` is 1 and `shiftAmt` equals WIDTH+2.
- R8: In a cycle with `inValid` low, the operands are ignored, and `shiftAmt` and `allZero` keep the values they held.
- R9: Valid operand sets on consecutive cycles each produce their own result, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand set on opA..opD is valid this cycle |
| opA | input | WIDTH | First aligned operand |
| opB | input | WIDTH | Second aligned operand |
| opC | input | WIDTH | Third aligned operand |
| opD | input | WIDTH | Fourth aligned operand |
| outValid | output | 1 | shiftAmt and allZero carry a new result |
| shiftAmt | output | $clog2(WIDTH+3) | Anticipated normalization shift |
| allZero | output | 1 | All operands were zero; shiftAmt forced to WIDTH+2 |

## Verification
The zero-forcing path and the back-to-back capture path can act in the same cycle. A zero operand set followed at once by a nonzero one must clear the flag and load a normal count in a single edge. A nonzero set followed by zeros must load the forced count. The bench provokes this with streams that alternate zero and nonzero sets with no idle gap, and with random gaps between them. A scoreboard tags each expected item with its issue cycle and judges the flag, the count and the one-position bound against the exact sum of that item only. Idle cycles between items change the operands, and the bench confirms that the held outputs do not move.

// File: rtl/lza4_pkg.sv
package lza4_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;
  } lzaStrobe_t;
endpackage

// File: rtl/lza4_column.sv
module lza4_column (
  input  logic bitA,
  input  logic bitB,
  input  logic bitC,
  input  logic bitD,
  output logic nonZero,
  output logic pairUp,
  output logic allFour
);
  logic [2:0] onesCount;
  logic [4:0] countHot;

  always_comb begin
    onesCount = {2'b00, bitA} + {2'b00, bitB} + {2'b00, bitC} + {2'b00, bitD};
    countHot  = 5'b00001 << onesCount;
    nonZero   = ~countHot[0];
    pairUp    = |countHot[4:2];
    allFour   = countHot[4];
  end
endmodule

// File: rtl/lza4_lzd.sv
module lza4_lzd #(
  parameter int LEN = 32,
  localparam int CW = $clog2(LEN)
) (
  input  logic [LEN-1:0] vec,
  output logic           found,
  output logic [CW-1:0]  zeros
);
  localparam int HALF = LEN / 2;

  generate
    if (LEN == 2) begin : g_leaf
      assign found = vec[1] | vec[0];
      assign zeros = ~vec[1];
    end else begin : g_merge
      logic            hiFound, loFound;
      logic [CW-2:0]   hiZeros, loZeros;
      lza4_lzd #(.LEN(HALF)) hi_i (.vec(vec[LEN-1:HALF]), .found(hiFound), .zeros(hiZeros));
      lza4_lzd #(.LEN(HALF)) lo_i (.vec(vec[HALF-1:0]),   .found(loFound), .zeros(loZeros));
      assign found = hiFound | loFound;
      assign zeros = hiFound ? {1'b0, hiZeros} : {1'b1, loZeros};
    end
  endgenerate
endmodule

// File: rtl/lza4_control.sv
module lza4_control
  import lza4_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output lzaStrobe_t strobe,
  output logic       outValid
);
  always_comb strobe.load = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/lza4_datapath.sv
module lza4_datapath
  import lza4_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int RES_W = WIDTH + 2,
  localparam int SHIFT_W = $clog2(RES_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  lzaStrobe_t         strobe,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [WIDTH-1:0]   opC,
  input  logic [WIDTH-1:0]   opD,
  output logic [SHIFT_W-1:0] shiftAmt,
  output logic               allZero
);
  localparam int PAD_W = 1 << $clog2(RES_W);
  localparam int LZD_W = $clog2(PAD_W);

  logic [WIDTH-1:0]   colNz, colPair, colFull;
  logic [RES_W-1:0]   indicator;
  logic [PAD_W-1:0]   lzdIn;
  logic               lzdFound;
  logic [LZD_W-1:0]   lzdZeros;
  logic [SHIFT_W-1:0] shiftNext;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_col
      lza4_column col_i (
        .bitA(opA[i]), .bitB(opB[i]), .bitC(opC[i]), .bitD(opD[i]),
        .nonZero(colNz[i]), .pairUp(colPair[i]), .allFour(colFull[i])
      );
    end

    for (genvar m = 0; m < RES_W; m++) begin : g_ind
      logic nz0, nz1, pr1, pr2, fl2;
      if (m < WIDTH) begin : g_c0
        assign nz0 = colNz[m];
      end else begin : g_c0z
        assign nz0 = 1'b0;
      end
      if (m >= 1 && m - 1 < WIDTH) begin : g_c1
        assign nz1 = colNz[m-1];
        assign pr1 = colPair[m-1];
      end else begin : g_c1z
        assign nz1 = 1'b0;
        assign pr1 = 1'b0;
      end
      if (m >= 2 && m - 2 < WIDTH) begin : g_c2
        assign pr2 = colPair[m-2];
        assign fl2 = colFull[m-2];
      end else begin : g_c2z
        assign pr2 = 1'b0;
        assign fl2 = 1'b0;
      end
      assign indicator[m] = nz0 | pr1 | (nz1 & pr2) | fl2;
    end

    if (PAD_W > RES_W) begin : g_pad
      assign lzdIn = {indicator, {(PAD_W - RES_W){1'b0}}};
    end else begin : g_nopad
      assign lzdIn = indicator;
    end
  endgenerate

  lza4_lzd #(.LEN(PAD_W)) lzd_i (.vec(lzdIn), .found(lzdFound), .zeros(lzdZeros));

  always_comb shiftNext = lzdFound ? SHIFT_W'(lzdZeros) : SHIFT_W'(RES_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftAmt <= '0;
      allZero  <= 1'b0;
    end else if (strobe.load) begin
      shiftAmt <= shiftNext;
      allZero  <= ~lzdFound;
    end
  end
endmodule

// File: rtl/lza4.sv
module lza4
  import lza4_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int SHIFT_W = $clog2(WIDTH + 3)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [WIDTH-1:0]   opC,
  input  logic [WIDTH-1:0]   opD,
  output logic               outValid,
  output logic [SHIFT_W-1:0] shiftAmt,
  output logic               allZero
);
  lzaStrobe_t strobe;

  lza4_control ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobe(strobe), .outValid(outValid)
  );

  lza4_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opA(opA), .opB(opB), .opC(opC), .opD(opD),
    .shiftAmt(shiftAmt), .allZero(allZero)
  );
endmodule

// File: rtl/lza4_checker.sv
module lza4_checker #(
  parameter int WIDTH = 16,
  localparam int SHIFT_W = $clog2(WIDTH + 3)
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic [WIDTH-1:0]   opC,
  input logic [WIDTH-1:0]   opD,
  input logic               outValid,
  input logic [SHIFT_W-1:0] shiftAmt,
  input logic               allZero
);
  localparam int RES_W = WIDTH + 2;

  logic [RES_W-1:0] sumAll;
  logic             anyOne;
  int               leadNow;
  int               leadReg;

  always_comb begin
    sumAll = RES_W'(opA) + RES_W'(opB) + RES_W'(opC) + RES_W'(opD);
    anyOne = |{opA, opB, opC, opD};
    leadNow = 0;
    for (int i = 0; i < RES_W; i++) if (sumAll[i]) leadNow = i;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        leadReg <= 0;
    else if (inValid) leadReg <= leadNow;
  end

  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid); // R2
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !outValid); // R2
  AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN) outValid && !allZero |-> int'(shiftAmt) < RES_W); // R5
  AST_LEAD_WITHIN_ONE: assert property (@(posedge clk) disable iff (!rstN) outValid && !allZero |-> (int'(shiftAmt) == RES_W - 1 - leadReg) || (int'(shiftAmt) == RES_W - leadReg)); // R6
  AST_ZERO_FULL_SHIFT: assert property (@(posedge clk) disable iff (!rstN) outValid && allZero |-> int'(shiftAmt) == RES_W); // R7
  AST_ZERO_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN) inValid && !anyOne |=> allZero); // R7
  AST_ZERO_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN) inValid && anyOne |=> !allZero); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> $stable(shiftAmt) && $stable(allZero)); // R8
endmodule

bind lza4 lza4_checker #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid),
  .opA(opA), .opB(opB), .opC(opC), .opD(opD),
  .outValid(outValid), .shiftAmt(shiftAmt), .allZero(allZero)
);

// File: tb/lza4_tb_top.sv
module lza4_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 16;
  localparam int RES_W = WIDTH + 2;
  localparam int SHIFT_W = $clog2(WIDTH + 3);

  typedef struct {
    int    issue;
    int    shift;
    bit    zero;
    int    lead;
    string tag;
  } expItem_t;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic [WIDTH-1:0]   opA = '0, opB = '0, opC = '0, opD = '0;
  logic               outValid;
  logic [SHIFT_W-1:0] shiftAmt;
  logic               allZero;

  expItem_t sbq[$];
  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  bit  monitorOn = 0;
  int  lastShift = 0;
  bit  lastZero = 0;
  bit  finished = 0;

  lza4 #(.WIDTH(WIDTH)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .opA(opA), .opB(opB), .opC(opC), .opD(opD),
    .outValid(outValid), .shiftAmt(shiftAmt), .allZero(allZero)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // Shift predicted from the indicator rule of R4 and R5
  function automatic int predShift(logic [WIDTH-1:0] a, b, c, d);
    int cnt[WIDTH+4];
    for (int i = 0; i < WIDTH + 4; i++) cnt[i] = 0;
    for (int i = 0; i < WIDTH; i++) cnt[i+2] = int'(a[i]) + int'(b[i]) + int'(c[i]) + int'(d[i]);
    for (int m = RES_W - 1; m >= 0; m--) begin
      if (cnt[m+2] >= 1 || cnt[m+1] >= 2 || (cnt[m+1] >= 1 && cnt[m] >= 2) || cnt[m] == 4)
        return RES_W - 1 - m;
    end
    return RES_W;
  endfunction

  function automatic int exactLead(logic [WIDTH-1:0] a, b, c, d);
    logic [RES_W-1:0] s;
    int ld;
    s = RES_W'(a) + RES_W'(b) + RES_W'(c) + RES_W'(d);
    ld = -1;
    for (int i = 0; i < RES_W; i++) if (s[i]) ld = i;
    return ld;
  endfunction

  task automatic drive(logic [WIDTH-1:0] a, b, c, d, string tag);
    expItem_t it;
    @(negedge clk);
    opA = a; opB = b; opC = c; opD = d;
    inValid = 1'b1;
    it.issue = cyc;
    it.lead  = exactLead(a, b, c, d);
    it.zero  = (it.lead < 0);
    it.shift = predShift(a, b, c, d);
    it.tag   = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = WIDTH'($urandom); opB = WIDTH'($urandom);
      opC = WIDTH'($urandom); opD = WIDTH'($urandom);
    end
  endtask

  // Monitor: pops the item issued one cycle earlier
  initial begin
    forever begin
      @(negedge clk);
      if (monitorOn) begin
        if (sbq.size() > 0 && sbq[0].issue == cyc - 1) begin
          expItem_t e;
          e = sbq.pop_front();
          check(outValid == 1'b1, "R2", "outValid after valid input", int'(outValid), 1);
          check(allZero == e.zero, e.zero ? "R7" : "R5", "allZero", int'(allZero), int'(e.zero));
          check(int'(shiftAmt) == e.shift, e.tag, "shiftAmt", int'(shiftAmt), e.shift);
          if (!e.zero)
            check(int'(shiftAmt) == RES_W - 1 - e.lead || int'(shiftAmt) == RES_W - e.lead,
                  "R6", "shift vs exact leading one", int'(shiftAmt), RES_W - 1 - e.lead);
          lastShift = e.shift;
          lastZero  = e.zero;
        end else begin
          check(outValid == 1'b0, "R2", "outValid without valid input", int'(outValid), 0);
          check(int'(shiftAmt) == lastShift, "R8", "shiftAmt held while idle", int'(shiftAmt), lastShift);
          check(allZero == lastZero, "R8", "allZero held while idle", int'(allZero), int'(lastZero));
        end
      end
    end
  end

  task automatic finishUp();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finishUp();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    check(allZero == 1'b0, "R1", "allZero in reset", int'(allZero), 0);
    check(shiftAmt == '0, "R1", "shiftAmt in reset", int'(shiftAmt), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid before first input", int'(outValid), 0);
    monitorOn = 1;

    drive('0, '0, '0, '0, "R7");                              // all zero: forced full width
    idle(2);
    drive(16'h0001, '0, '0, '0, "R5");                        // single LSB: shift 17
    idle(1);
    drive(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R4");      // column count 4 at top
    drive(16'h8000, 16'h8000, '0, '0, "R3");                  // pair in top column
    drive(16'h000F, 16'h0003, 16'h0003, 16'h0003, "R6");      // prediction one below true lead
    drive(16'h0003, 16'h0002, 16'h0002, '0, "R3");            // count 3 and 1
    drive(16'h0100, 16'h0100, 16'h0100, 16'h0100, "R4");      // allFour mid
    idle(3);
    // R9: back-to-back, alternating zero and nonzero
    for (int k = 0; k < 10; k++) begin
      if (k % 2 == 0) drive('0, '0, '0, '0, "R9");
      else drive(WIDTH'($urandom), WIDTH'($urandom), '0, WIDTH'($urandom), "R9");
    end
    idle(2);
    // Random mix with gaps and varied magnitudes
    for (int k = 0; k < 300; k++) begin
      int sh;
      logic [WIDTH-1:0] msk;
      sh  = $urandom % WIDTH;
      msk = {WIDTH{1'b1}} >> sh;
      drive(WIDTH'($urandom) & msk, WIDTH'($urandom) & msk,
            WIDTH'($urandom) & msk, WIDTH'($urandom) & msk, "R4");
      if ($urandom % 3 == 0) idle(1 + $urandom % 3);
    end
    idle(3);
    check(sbq.size() == 0, "R9", "scoreboard drained", sbq.size(), 0);
    finishUp();
  end
endmodule